// File: doc/BRIEF.md
# Counter Data Port Byte Sequencer

This block is the per-channel byte sequencer of a programmable interval timer. It sits between an 8-bit data port and a 16-bit down-counter. A control word selects how count bytes move across the port: low byte only, high byte only, or low byte then high byte. On the write side, the block builds the 16-bit count from the incoming bytes. One clock after the count is complete, it emits a one-cycle load strobe together with the assembled value.

On the read side, the block presents one byte of the count at a time on a combinational read port. When a read strobe arrives, it steps to the next byte. A latch command freezes a snapshot of the live count, and reads return that snapshot until every byte of it has been taken. A two-byte read of the live count also takes a snapshot when the low byte is read, so the high byte comes from the same instant.

The write and read byte pointers advance independently. A half-done flag tells the channel that a two-byte write is in progress, so it can stop counting meanwhile. Bytes are carried unaltered, which means a count kept in packed BCD passes through as packed digits.

Top module: `count_port_sequencer`

## Requirements
- R1: After reset the access mode is low-then-high (code 11), both byte pointers sit on the low byte, no snapshot is frozen, `loadStrobe` is 0 and `writeHalfDone` is 0, so `rdData` shows the low byte of `liveCount`.
- R2: In low-only mode (code 01), every data write raises `loadStrobe` for one cycle, starting the cycle after the write. `loadValue` is then {8'h00, byte}.
- R3: In high-only mode (code 10), every data write raises `loadStrobe` for one cycle, starting the cycle after the write. `loadValue` is then {byte, 8'h00}.
- R4: In low-then-high mode, the first write raises no strobe and sets `writeHalfDone`. The second write clears `writeHalfDone` and raises `loadStrobe` with `loadValue` = {second byte, first byte}.
- R5: In low-only mode every read returns bits 7:0 of the count. In high-only mode every read returns bits 15:8.
- R6: In low-then-high mode, reads alternate low byte then high byte. Reading the low byte of the live count captures the whole count, so the following high-byte read returns the high byte from that same instant. The read after that tracks the live count again.
- R7: A control word with access code 00 is a latch command. It freezes `liveCount`, and reads return the frozen value until all of its bytes have been read: one byte in single-byte modes, two in low-then-high mode. Reads then follow the live count. The latch command leaves the access mode unchanged.
- R8: A latch command that arrives while a snapshot is still frozen is ignored, and the first snapshot is kept.
- R9: A control word with a nonzero access code sets the access mode, returns both byte pointers to the low byte (clearing `writeHalfDone`) and releases any frozen snapshot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctlWrite | input | 1 | Control word strobe for this channel |
| ctlAccess | input | 2 | Access field of the control word: 00 latch, 01 low, 10 high, 11 low then high |
| wrStrobe | input | 1 | Data port write strobe |
| wrData | input | 8 | Data port write byte |
| rdStrobe | input | 1 | Data port read strobe; advances the read pointer |
| rdData | output | 8 | Byte currently presented for reading |
| liveCount | input | 16 | Live count from the counter |
| loadStrobe | output | 1 | One-cycle strobe: a complete count is ready |
| loadValue | output | 16 | Assembled count, valid with `loadStrobe` |
| writeHalfDone | output | 1 | First byte of a two-byte write received |

## Verification
The assertions assume that a control word, a data write and a data read never share a cycle, and that each strobe lasts one cycle. They also assume that `liveCount` changes only between port accesses. The stimulus holds every strobe for exactly one clock and spaces operations at least one idle clock apart. It changes the live count only through separate table steps, so each access sees a settled count.

// File: rtl/cps_pkg.sv
package cps_pkg;
  typedef enum logic [1:0] {
    ACC_LATCH = 2'b00,
    ACC_LOW   = 2'b01,
    ACC_HIGH  = 2'b10,
    ACC_BOTH  = 2'b11
  } accMode_t;

  typedef struct packed {
    logic captureLow;
    logic loadLow;
    logic loadHigh;
    logic loadPair;
    logic snapshot;
    logic readHigh;
    logic useHold;
  } seqCtl_t;
endpackage

// File: rtl/cps_ctrl.sv
module cps_ctrl
  import cps_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       ctlWrite,
  input  logic [1:0] ctlAccess,
  input  logic       wrStrobe,
  input  logic       rdStrobe,
  output seqCtl_t    ctl,
  output logic       halfDone
);
  accMode_t accMode;
  logic wrHigh, rdHigh, frozen;
  logic isLatch, isSetup, wrGo, rdGo, lastRead;

  assign isLatch = ctlWrite && (ctlAccess == ACC_LATCH);
  assign isSetup = ctlWrite && (ctlAccess != ACC_LATCH);
  assign wrGo    = wrStrobe && !ctlWrite;
  assign rdGo    = rdStrobe && !ctlWrite;
  assign lastRead = rdGo && ((accMode != ACC_BOTH) || rdHigh);
  assign halfDone = wrHigh;

  always_comb begin
    ctl = '0;
    ctl.useHold  = frozen;
    ctl.readHigh = (accMode == ACC_HIGH) || ((accMode == ACC_BOTH) && rdHigh);
    if (wrGo) begin
      case (accMode)
        ACC_LOW:  ctl.loadLow = 1'b1;
        ACC_HIGH: ctl.loadHigh = 1'b1;
        ACC_BOTH: begin
          if (wrHigh) ctl.loadPair = 1'b1;
          else        ctl.captureLow = 1'b1;
        end
        default: ;
      endcase
    end
    ctl.snapshot = !frozen &&
                   (isLatch || (rdGo && (accMode == ACC_BOTH) && !rdHigh));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accMode <= ACC_BOTH;
      wrHigh  <= 1'b0;
      rdHigh  <= 1'b0;
      frozen  <= 1'b0;
    end else if (isSetup) begin
      accMode <= accMode_t'(ctlAccess);
      wrHigh  <= 1'b0;
      rdHigh  <= 1'b0;
      frozen  <= 1'b0;
    end else begin
      if (ctl.snapshot) frozen <= 1'b1;
      else if (lastRead) frozen <= 1'b0;
      if (wrGo && (accMode == ACC_BOTH)) wrHigh <= !wrHigh;
      if (rdGo && (accMode == ACC_BOTH)) rdHigh <= !rdHigh;
    end
  end

  // R4
  half_only_two_byte_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrHigh |-> (accMode == ACC_BOTH));

  // R9
  setup_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    isSetup |=> (!wrHigh && !rdHigh && !frozen));

  // R8
  relatch_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (frozen && isLatch) |=> frozen);

  // R4
  first_byte_pends_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrGo && (accMode == ACC_BOTH) && !wrHigh) |=> wrHigh);
endmodule

// File: rtl/cps_datapath.sv
module cps_datapath
  import cps_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int CNT_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqCtl_t           ctl,
  input  logic [BYTE_W-1:0] wrData,
  input  logic [CNT_W-1:0]  liveCount,
  output logic [BYTE_W-1:0] rdData,
  output logic              loadStrobe,
  output logic [CNT_W-1:0]  loadValue
);
  logic [BYTE_W-1:0] lowByte;
  logic [CNT_W-1:0]  holdVal;
  logic [CNT_W-1:0]  srcVal;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lowByte    <= '0;
      holdVal    <= '0;
      loadStrobe <= 1'b0;
      loadValue  <= '0;
    end else begin
      if (ctl.captureLow) lowByte <= wrData;
      if (ctl.snapshot)   holdVal <= liveCount;
      loadStrobe <= ctl.loadLow || ctl.loadHigh || ctl.loadPair;
      if (ctl.loadLow)       loadValue <= {{BYTE_W{1'b0}}, wrData};
      else if (ctl.loadHigh) loadValue <= {wrData, {BYTE_W{1'b0}}};
      else if (ctl.loadPair) loadValue <= {wrData, lowByte};
    end
  end

  assign srcVal = ctl.useHold ? holdVal : liveCount;
  assign rdData = ctl.readHigh ? srcVal[CNT_W-1:BYTE_W] : srcVal[BYTE_W-1:0];

  // R2
  low_only_zero_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.loadLow |=> (loadStrobe && (loadValue[CNT_W-1:BYTE_W] == '0)));

  // R3
  high_only_zero_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.loadHigh |=> (loadStrobe && (loadValue[BYTE_W-1:0] == '0)));

  // R7
  frozen_hold_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.useHold |=> $stable(holdVal));

  // R4
  no_strobe_on_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.captureLow |=> !loadStrobe);
endmodule

// File: rtl/count_port_sequencer.sv
module count_port_sequencer
  import cps_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int CNT_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctlWrite,
  input  logic [1:0]        ctlAccess,
  input  logic              wrStrobe,
  input  logic [BYTE_W-1:0] wrData,
  input  logic              rdStrobe,
  output logic [BYTE_W-1:0] rdData,
  input  logic [CNT_W-1:0]  liveCount,
  output logic              loadStrobe,
  output logic [CNT_W-1:0]  loadValue,
  output logic              writeHalfDone
);
  seqCtl_t ctl;

  cps_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .ctlWrite(ctlWrite), .ctlAccess(ctlAccess),
    .wrStrobe(wrStrobe), .rdStrobe(rdStrobe), .ctl(ctl), .halfDone(writeHalfDone)
  );

  cps_datapath #(.BYTE_W(BYTE_W)) dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .wrData(wrData), .liveCount(liveCount),
    .rdData(rdData), .loadStrobe(loadStrobe), .loadValue(loadValue)
  );
endmodule

// File: tb/count_port_sequencer_tb.sv
`timescale 1ns/1ps
module count_port_sequencer_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ctlWrite = 1'b0;
  logic [1:0] ctlAccess = 2'b00;
  logic wrStrobe = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic rdStrobe = 1'b0;
  logic [7:0] rdData;
  logic [15:0] liveCount = 16'h0000;
  logic loadStrobe;
  logic [15:0] loadValue;
  logic writeHalfDone;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  count_port_sequencer dut_i (
    .clk(clk), .rstN(rstN), .ctlWrite(ctlWrite), .ctlAccess(ctlAccess),
    .wrStrobe(wrStrobe), .wrData(wrData), .rdStrobe(rdStrobe), .rdData(rdData),
    .liveCount(liveCount), .loadStrobe(loadStrobe), .loadValue(loadValue),
    .writeHalfDone(writeHalfDone)
  );

  // ops: 1 write expect strobe+value, 2 write expect no strobe+halfDone,
  //      3 read expect byte, 4 control word (arg[1:0]), 5 set live count
  localparam int NV = 28;
  localparam logic [34:0] VEC [NV] = '{
    {3'd4, 16'h0001, 16'h0000},  // R2 low-only
    {3'd1, 16'h005A, 16'h005A},
    {3'd1, 16'h00C3, 16'h00C3},
    {3'd4, 16'h0002, 16'h0000},  // R3 high-only
    {3'd1, 16'h003C, 16'h3C00},
    {3'd4, 16'h0003, 16'h0000},  // R4 pair
    {3'd2, 16'h0034, 16'h0000},
    {3'd1, 16'h0012, 16'h1234},
    {3'd2, 16'h0099, 16'h0000},
    {3'd1, 16'h0042, 16'h4299},
    {3'd5, 16'hBEEF, 16'h0000},  // R5
    {3'd4, 16'h0001, 16'h0000},
    {3'd3, 16'h0000, 16'h00EF},
    {3'd3, 16'h0000, 16'h00EF},
    {3'd4, 16'h0002, 16'h0000},
    {3'd3, 16'h0000, 16'h00BE},
    {3'd4, 16'h0003, 16'h0000},  // R6
    {3'd3, 16'h0000, 16'h00EF},
    {3'd5, 16'h1111, 16'h0000},
    {3'd3, 16'h0000, 16'h00BE},
    {3'd3, 16'h0000, 16'h0011},
    {3'd3, 16'h0000, 16'h0011},
    {3'd5, 16'hA1B2, 16'h0000},  // R7 latch in pair mode
    {3'd4, 16'h0000, 16'h0000},
    {3'd5, 16'h0000, 16'h0000},
    {3'd3, 16'h0000, 16'h00B2},
    {3'd3, 16'h0000, 16'h00A1},
    {3'd3, 16'h0000, 16'h0000}
  };

  task automatic check(input bit ok, input string req, input logic [15:0] act,
                       input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doCtl(input logic [1:0] acc);
    ctlWrite = 1'b1; ctlAccess = acc;
    @(negedge clk);
    ctlWrite = 1'b0;
    @(negedge clk);
  endtask

  task automatic doWrite(input logic [7:0] b, output logic stb,
                         output logic [15:0] val, output logic half);
    wrStrobe = 1'b1; wrData = b;
    @(negedge clk);
    wrStrobe = 1'b0;
    stb = loadStrobe; val = loadValue; half = writeHalfDone;
    @(negedge clk);
  endtask

  task automatic doRead(output logic [7:0] b);
    b = rdData;
    rdStrobe = 1'b1;
    @(negedge clk);
    rdStrobe = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic stb, half;
    logic [15:0] val;
    logic [7:0] b;
    liveCount = 16'h5678;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(loadStrobe == 1'b0, "R1 strobe", {15'd0, loadStrobe}, 16'h0);
    check(writeHalfDone == 1'b0, "R1 halfDone", {15'd0, writeHalfDone}, 16'h0);
    check(rdData == 8'h78, "R1 rdData", {8'h0, rdData}, 16'h0078);
    doWrite(8'h11, stb, val, half);
    check(!stb && half, "R1 default pair mode", {14'd0, stb, half}, 16'h0001);
    doCtl(2'b11);

    for (int i = 0; i < NV; i++) begin
      logic [2:0] op;
      logic [15:0] arg, exp;
      {op, arg, exp} = VEC[i];
      case (op)
        3'd1: begin
          doWrite(arg[7:0], stb, val, half);
          check(stb && val == exp, "R2/R3/R4 load", val, exp);
        end
        3'd2: begin
          doWrite(arg[7:0], stb, val, half);
          check(!stb && half, "R4 pending", {14'd0, stb, half}, 16'h0001);
        end
        3'd3: begin
          doRead(b);
          check(b == exp[7:0], "R5/R6/R7 read", {8'h0, b}, exp);
        end
        3'd4: doCtl(arg[1:0]);
        default: begin liveCount = arg; @(negedge clk); end
      endcase
    end

    // R7 single-byte mode releases after one read
    doCtl(2'b01);
    liveCount = 16'h00AA;
    doCtl(2'b00);
    liveCount = 16'h00BB;
    doRead(b); check(b == 8'hAA, "R7 single frozen", {8'h0, b}, 16'h00AA);
    doRead(b); check(b == 8'hBB, "R7 single release", {8'h0, b}, 16'h00BB);

    // R8 second latch ignored
    doCtl(2'b11);
    liveCount = 16'h1357;
    doCtl(2'b00);
    liveCount = 16'h2468;
    doCtl(2'b00);
    doRead(b); check(b == 8'h57, "R8 low kept", {8'h0, b}, 16'h0057);
    doRead(b); check(b == 8'h13, "R8 high kept", {8'h0, b}, 16'h0013);
    doRead(b); check(b == 8'h68, "R8 live after", {8'h0, b}, 16'h0068);
    doRead(b);

    // R9 control word releases frozen snapshot
    liveCount = 16'hCAFE;
    doCtl(2'b00);
    liveCount = 16'hF00D;
    doCtl(2'b11);
    doRead(b); check(b == 8'h0D, "R9 release latch", {8'h0, b}, 16'h000D);
    // R9 read pointer reset mid-pair
    doCtl(2'b11);
    doRead(b); check(b == 8'h0D, "R9 read ptr reset", {8'h0, b}, 16'h000D);
    // R9 write pointer reset mid-pair
    doCtl(2'b11);
    doWrite(8'h55, stb, val, half);
    check(half, "R9 half set", {15'd0, half}, 16'h0001);
    doCtl(2'b11);
    check(writeHalfDone == 1'b0, "R9 half cleared", {15'd0, writeHalfDone}, 16'h0);
    doWrite(8'h77, stb, val, half);
    check(!stb && half, "R9 restart low", {14'd0, stb, half}, 16'h0001);
    doWrite(8'h88, stb, val, half);
    check(stb && val == 16'h8877 && !half, "R9 pair after reset", val, 16'h8877);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule